// File: doc/BRIEF.md
# Multi-Level Chained-Grant Bus Arbiter

This block is a central bus arbiter for a shared bus whose devices are grouped into several priority levels. Each level has one request line, the wired OR of every device request in that level. Each level also has one grant line. The grant line enters the device nearest the arbiter first and then ripples from device to device. The model holds the arbiter and a fixed number of chained device slots per level. A slot that is requesting when the grant reaches it takes the grant and reports itself granted. A slot that is not requesting passes the grant on to the next slot. A grant that leaves the far end of a chain unclaimed is reported for that level.

The arbiter waits until the shared bus-busy line is low. It then offers a grant to the highest-numbered level that has a pending request. It holds that grant steady until the winning device raises busy, and then it drops the grant. It arbitrates again only after busy falls. If the requests on the offered level disappear before busy rises, the offer is withdrawn on the next clock and the arbiter returns to idle. Devices assert busy from their own logic; the block only observes it.

Top module: `prio_chain_arbiter`

## Requirements
- R1: While reset is asserted, and until the first arbitration after it, `level_grant`, `dev_granted` and `level_unclaimed` are all zero.
- R2: `level_req[l]` is the OR of the device requests of level l, where device d of level l is bit `l*SLOTS_PER_LEVEL + d` of `dev_req`; it follows the inputs with no clock delay.
- R3: When the arbiter is idle and `bus_busy` is low, a clock edge that samples any level request raises exactly one `level_grant` bit, the highest-numbered requesting level. Before that edge no grant bit is set.
- R4: Within the granted level, `dev_granted` is set only for the requesting slot with the lowest index, where index 0 is the slot nearest the arbiter. All other devices read zero.
- R5: A slot that is not requesting passes the grant along the chain. If no slot of the granted level is requesting, `level_unclaimed` is set for that level.
- R6: While `bus_busy` is high and no grant is outstanding, no grant is issued, however many requests are pending.
- R7: An offered grant stays unchanged while its level still requests and `bus_busy` is low. This holds even if a higher level starts requesting.
- R8: A clock edge that samples `bus_busy` high while a grant is offered clears the grant. The next grant can rise no earlier than the second edge after `bus_busy` is sampled low again.
- R9: If the granted level stops requesting before `bus_busy` rises, the grant is cleared at the next edge and the arbiter is ready to grant again on the following edge.
- R10: A slot nearer the arbiter that keeps requesting wins every arbitration round of its level, and a farther requesting slot of that level is never granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| dev_req | input | NUM_LEVELS*SLOTS_PER_LEVEL | Per-device request, level-major, slot 0 nearest the arbiter |
| bus_busy | input | 1 | Shared busy line driven by the current bus owner |
| dev_granted | output | NUM_LEVELS*SLOTS_PER_LEVEL | Device holds the grant of its level |
| level_req | output | NUM_LEVELS | Wired-OR request line of each level |
| level_grant | output | NUM_LEVELS | Grant line driven by the arbiter into each chain |
| level_unclaimed | output | NUM_LEVELS | Grant passed the end of the chain with no taker |

## Verification
The bench builds the block with three levels of three slots each, so the 9-bit request vector has only 512 values. It applies every one of them from idle. For each value it checks the request lines, the grant latency, the winning device, the unclaimed flag after the requests are removed, and the withdrawal of the grant. This covers every tie between levels and between slots of the same level. Directed sequences then exercise busy-blocked requests, the hold of an offered grant when a higher level starts requesting, the release and re-arbitration timing, and repeated rounds in which a near slot locks out a far one.

// File: rtl/arb_pkg.sv
package arb_pkg;

  // Arbiter sequencing states
  typedef enum logic [1:0] {
    ARB_IDLE  = 2'd0,  // no grant, waiting for a free bus and a request
    ARB_OFFER = 2'd1,  // grant driven, waiting for the winner to take the bus
    ARB_OWNED = 2'd2   // bus taken, waiting for busy to drop
  } arb_state_e;

endpackage

// File: rtl/arb_rst_sync.sv
module arb_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_n_sync = sync_q[1];

endmodule

// File: rtl/arb_chain_slot.sv
module arb_chain_slot (
  input  logic grant_in,
  input  logic req,
  output logic grant_out,
  output logic granted
);

  // A requesting slot absorbs the grant; an idle slot forwards it.
  always_comb begin
    granted   = grant_in & req;
    grant_out = grant_in & ~req;
  end

endmodule

// File: rtl/arb_level_chain.sv
module arb_level_chain #(
  parameter int SLOTS = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             grant_in,
  input  logic [SLOTS-1:0] req,
  output logic             any_req,
  output logic [SLOTS-1:0] granted,
  output logic             unclaimed
);

  logic [SLOTS:0] gnt_ripple;

  assign gnt_ripple[0] = grant_in;

  genvar s;
  generate
    for (s = 0; s < SLOTS; s++) begin : g_slot
      arb_chain_slot u_slot (
        .grant_in  (gnt_ripple[s]),
        .req       (req[s]),
        .grant_out (gnt_ripple[s+1]),
        .granted   (granted[s])
      );
    end
  endgenerate

  assign any_req   = |req;
  assign unclaimed = gnt_ripple[SLOTS];

  // R4
  chain_single_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(granted));

  // R5
  chain_taken_when_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_in && any_req) |-> (!unclaimed && (granted != '0)));

endmodule

// File: rtl/arb_ctrl.sv
module arb_ctrl
  import arb_pkg::*;
#(
  parameter int NUM_LEVELS = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_LEVELS-1:0] level_req,
  input  logic                  bus_busy,
  output logic [NUM_LEVELS-1:0] level_grant
);

  arb_state_e            state_q, state_d;
  logic [NUM_LEVELS-1:0] grant_q, grant_d;
  logic                  grant_load;
  logic                  state_load;
  logic [NUM_LEVELS-1:0] top_pick;

  // Highest-numbered requesting level
  always_comb begin
    top_pick = '0;
    for (int i = 0; i < NUM_LEVELS; i++) begin
      if (level_req[i]) begin
        top_pick    = '0;
        top_pick[i] = 1'b1;
      end
    end
  end

  // Next-state logic
  always_comb begin
    state_d    = state_q;
    grant_d    = grant_q;
    grant_load = 1'b0;
    unique case (state_q)
      ARB_IDLE: begin
        if (!bus_busy && (level_req != '0)) begin
          state_d    = ARB_OFFER;
          grant_d    = top_pick;
          grant_load = 1'b1;
        end
      end
      ARB_OFFER: begin
        if (bus_busy) begin
          state_d    = ARB_OWNED;
          grant_d    = '0;
          grant_load = 1'b1;
        end else if ((level_req & grant_q) == '0) begin
          state_d    = ARB_IDLE;
          grant_d    = '0;
          grant_load = 1'b1;
        end
      end
      ARB_OWNED: begin
        if (!bus_busy) begin
          state_d = ARB_IDLE;
        end
      end
      default: begin
        state_d    = ARB_IDLE;
        grant_d    = '0;
        grant_load = 1'b1;
      end
    endcase
  end

  assign state_load = (state_d != state_q);

  // Registers with explicit enables
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ARB_IDLE;
    end else if (state_load) begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grant_q <= '0;
    end else if (grant_load) begin
      grant_q <= grant_d;
    end
  end

  assign level_grant = grant_q;

  // R3
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_q));

  // R3
  grant_top_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(|grant_q) |-> (($past(level_req) & ~(grant_q | (grant_q - 1'b1))) == '0));

  // R6
  no_grant_on_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(|grant_q) |-> !$past(bus_busy));

  // R8
  grant_drop_on_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((grant_q != '0) && bus_busy) |=> (grant_q == '0));

  // R7
  grant_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((grant_q != '0) && !bus_busy && ((level_req & grant_q) != '0)) |=> $stable(grant_q));

  // R9
  grant_withdraw_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((grant_q != '0) && !bus_busy && ((level_req & grant_q) == '0)) |=> (grant_q == '0));

endmodule

// File: rtl/prio_chain_arbiter.sv
module prio_chain_arbiter #(
  parameter int NUM_LEVELS      = 4,
  parameter int SLOTS_PER_LEVEL = 4,
  localparam int NDEV           = NUM_LEVELS * SLOTS_PER_LEVEL
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NDEV-1:0]       dev_req,
  input  logic                  bus_busy,
  output logic [NDEV-1:0]       dev_granted,
  output logic [NUM_LEVELS-1:0] level_req,
  output logic [NUM_LEVELS-1:0] level_grant,
  output logic [NUM_LEVELS-1:0] level_unclaimed
);

  logic rst_n_sync;

  arb_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  arb_ctrl #(
    .NUM_LEVELS (NUM_LEVELS)
  ) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n_sync),
    .level_req   (level_req),
    .bus_busy    (bus_busy),
    .level_grant (level_grant)
  );

  genvar l;
  generate
    for (l = 0; l < NUM_LEVELS; l++) begin : g_level
      arb_level_chain #(
        .SLOTS (SLOTS_PER_LEVEL)
      ) u_chain (
        .clk       (clk),
        .rst_n     (rst_n_sync),
        .grant_in  (level_grant[l]),
        .req       (dev_req[l*SLOTS_PER_LEVEL +: SLOTS_PER_LEVEL]),
        .any_req   (level_req[l]),
        .granted   (dev_granted[l*SLOTS_PER_LEVEL +: SLOTS_PER_LEVEL]),
        .unclaimed (level_unclaimed[l])
      );
    end
  endgenerate

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n_sync |-> ((dev_granted == '0) && (level_unclaimed == '0)));

endmodule

// File: tb/prio_chain_arbiter_bench.sv
module prio_chain_arbiter_bench;

  localparam int L      = 3;
  localparam int S      = 3;
  localparam int NDEV   = L * S;
  localparam int PERIOD = 10;

  logic            clk;
  logic            rst_n;
  logic [NDEV-1:0] dev_req;
  logic            bus_busy;
  logic [NDEV-1:0] dev_granted;
  logic [L-1:0]    level_req;
  logic [L-1:0]    level_grant;
  logic [L-1:0]    level_unclaimed;

  int checks;
  int failures;
  bit done;

  prio_chain_arbiter #(
    .NUM_LEVELS      (L),
    .SLOTS_PER_LEVEL (S)
  ) u_prio_chain_arbiter (
    .clk             (clk),
    .rst_n           (rst_n),
    .dev_req         (dev_req),
    .bus_busy        (bus_busy),
    .dev_granted     (dev_granted),
    .level_req       (level_req),
    .level_grant     (level_grant),
    .level_unclaimed (level_unclaimed)
  );

  initial clk = 1'b0;
  always #(PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  function automatic logic [L-1:0] exp_levels(input int p);
    logic [L-1:0] r = '0;
    for (int l = 0; l < L; l++) r[l] = (((p >> (l*S)) & ((1 << S) - 1)) != 0);
    return r;
  endfunction

  function automatic logic [L-1:0] exp_win_level(input int p);
    logic [L-1:0] r = '0;
    for (int l = L-1; l >= 0; l--) begin
      if (((p >> (l*S)) & ((1 << S) - 1)) != 0) begin
        r[l] = 1'b1;
        return r;
      end
    end
    return r;
  endfunction

  function automatic logic [NDEV-1:0] exp_win_dev(input int p);
    logic [NDEV-1:0] r = '0;
    for (int l = L-1; l >= 0; l--) begin
      int grp = (p >> (l*S)) & ((1 << S) - 1);
      if (grp != 0) begin
        for (int j = 0; j < S; j++) begin
          if (grp[j]) begin
            r[l*S + j] = 1'b1;
            return r;
          end
        end
      end
    end
    return r;
  endfunction

  initial begin
    int cyc = 0;
    while (!done && cyc < 20000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=done", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    checks   = 0;
    failures = 0;
    done     = 1'b0;
    rst_n    = 1'b0;
    bus_busy = 1'b0;
    dev_req  = 9'b000_000_001;
    repeat (3) tick();
    // R1: quiet during reset even with a pending request
    check("R1 grant in reset", 32'(level_grant), 32'd0);
    check("R1 granted in reset", 32'(dev_granted), 32'd0);
    check("R1 unclaimed in reset", 32'(level_unclaimed), 32'd0);
    dev_req = '0;
    rst_n   = 1'b1;
    repeat (4) tick();
    check("R1 grant after reset", 32'(level_grant), 32'd0);

    // Exhaustive sweep over all request patterns (R2 R3 R4 R5 R9)
    for (int p = 0; p < (1 << NDEV); p++) begin
      dev_req  = p[NDEV-1:0];
      bus_busy = 1'b0;
      #1;
      check("R2 level_req", 32'(level_req), 32'(exp_levels(p)));
      check("R3 no grant before edge", 32'(level_grant), 32'd0);
      tick();
      check("R3 winning level", 32'(level_grant), 32'(exp_win_level(p)));
      check("R4 winning device", 32'(dev_granted), 32'(exp_win_dev(p)));
      check("R5 claimed", 32'(level_unclaimed), 32'd0);
      dev_req = '0;
      #1;
      check("R5 unclaimed passthrough", 32'(level_unclaimed), 32'(exp_win_level(p)));
      tick();
      check("R9 withdraw", 32'(level_grant), 32'd0);
    end

    // R6: busy blocks new grants
    dev_req  = 9'b000_000_001;
    bus_busy = 1'b1;
    for (int k = 0; k < 3; k++) begin
      tick();
      check("R6 blocked by busy", 32'(level_grant), 32'd0);
    end
    bus_busy = 1'b0;
    tick();
    check("R6 grant after busy low", 32'(level_grant), 32'b001);
    check("R6 device after busy low", 32'(dev_granted), 32'h001);

    // R8: busy taken clears grant, re-arbitration after release
    bus_busy = 1'b1;
    tick();
    check("R8 grant dropped", 32'(level_grant), 32'd0);
    dev_req = 9'b010_000_000;
    for (int k = 0; k < 3; k++) begin
      tick();
      check("R8 held off while owned", 32'(level_grant), 32'd0);
    end
    bus_busy = 1'b0;
    tick();
    check("R8 first edge after release", 32'(level_grant), 32'd0);
    tick();
    check("R8 regrant level", 32'(level_grant), 32'b100);
    check("R8 regrant device", 32'(dev_granted), 32'h080);
    dev_req = '0;
    tick();
    check("R9 idle again", 32'(level_grant), 32'd0);

    // R7: offered grant stays when a higher level starts requesting
    dev_req = 9'b000_000_010;
    tick();
    check("R7 initial offer", 32'(level_grant), 32'b001);
    dev_req = 9'b001_000_010;
    for (int k = 0; k < 2; k++) begin
      tick();
      check("R7 grant stable", 32'(level_grant), 32'b001);
      check("R7 device stable", 32'(dev_granted), 32'h002);
    end
    bus_busy = 1'b1;
    tick();
    dev_req  = '0;
    bus_busy = 1'b0;
    tick();
    tick();

    // R10: near slot keeps winning over a far slot in its level
    dev_req = 9'b000_101_000;
    for (int r = 0; r < 4; r++) begin
      tick();
      check("R10 near slot wins", 32'(dev_granted), 32'h008);
      bus_busy = 1'b1;
      tick();
      check("R10 no device while owned", 32'(dev_granted), 32'd0);
      bus_busy = 1'b0;
      tick();
    end
    dev_req = '0;
    tick();

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule